// File: doc/BRIEF.md
# Bridge Drain-Source Fault Monitor

This block decides when an over-threshold drain-source comparator flag on a power MOSFET of a multi-phase full bridge is a real fault. Each phase has a high-side and a low-side device. Each device has its own gate command and its own comparator flag. A flag is honoured only while its own device is commanded on, and only once a settling window has passed since that phase last switched. A qualified flag sets the fault bit of its phase. The OR of all phase bits forms the bridge-fault request that a protection controller uses to put the bridge into coast.

The settling window adapts to what came before. After an ordinary switching event it lasts two dead times. When a phase turns a device on after it has been fully off (both commands low) for a long interval, one dead time is enough. A separate supply-drain sense flag acts like a short to ground on the high side of every phase at once. The dead time and the long-interval threshold are parameters counted in clock cycles. All inputs are assumed to be synchronous to `clk`.

Top module: `vds_fault_monitor`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `phase_fault` and `bridge_fault` are all zero.
- R2: A comparator flag has no effect while its device's gate command is low. With all gates off and all flags high, no fault is raised.
- R3: With `gate_hi[p]` high and `vds_hi_over[p]` high past the window, `phase_fault[p]` is set. This is how a motor lead shorted to ground is reported.
- R4: The low side is checked on its own path. `vds_lo_over[p]` counts only while `gate_lo[p]` is high, and a high-side flag never qualifies through a low-side command, nor the reverse.
- R5: A phase command is the pair {gate_hi, gate_lo}. Any change of this pair starts a blanking window of L cycles. L is 2*DEAD_CYCLES normally. If the new command is seen at rising edge E1 and the flag is held high, `phase_fault[p]` first reads high after edge E(L+1).
- R6: L is DEAD_CYCLES instead when a device is turned on after the phase held both commands low for at least LONG_DT*DEAD_CYCLES consecutive rising edges.
- R7: An off interval of one edge fewer than LONG_DT*DEAD_CYCLES gives the normal window, 2*DEAD_CYCLES.
- R8: A command change during a running window restarts the window at its full length, counted from the new change.
- R9: While `drain_sense_fault` is high, every phase whose high side is commanded on and past its window reads as faulted one edge later, whatever its own flags show.
- R10: `bridge_fault` equals the OR of `phase_fault` on every cycle.
- R11: Faults are not latched. Once a qualified flag drops, its `phase_fault` bit clears at the next edge.
- R12: Phases are independent. Switching one phase never blanks or clears the fault of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gate_hi | input | NUM_PHASES | High-side gate command per phase |
| gate_lo | input | NUM_PHASES | Low-side gate command per phase |
| vds_hi_over | input | NUM_PHASES | High-side drain-source over-threshold flag |
| vds_lo_over | input | NUM_PHASES | Low-side drain-source over-threshold flag |
| drain_sense_fault | input | 1 | Supply-drain sense fault, applied to every high side |
| phase_fault | output | NUM_PHASES | Registered per-phase fault |
| bridge_fault | output | 1 | Registered OR of all phase faults |

## Verification
After a command change, the fault output is due exactly L+1 rising edges later, with L equal to 2*DEAD_CYCLES or to DEAD_CYCLES. Once a phase is armed, a flag or drain-sense change shows up one edge later. The bench changes inputs on the falling edge and samples on the next falling edge, counting rising edges in between. This lets it measure the arrival edge of a fault and compare it with the expected L+1. It sweeps the off-interval length across the long threshold on both sides of every phase. Absence checks (no fault) are sampled after enough edges for any window to have expired.

// File: rtl/vdsm_pkg.sv
package vdsm_pkg;

  // Phase command: bit 1 = high-side on, bit 0 = low-side on
  typedef enum logic [1:0] {
    PH_IDLE  = 2'b00,
    PH_LOW   = 2'b01,
    PH_HIGH  = 2'b10,
    PH_SHOOT = 2'b11
  } phase_cmd_e;

  function automatic phase_cmd_e decode_cmd(input logic hi, input logic lo);
    return phase_cmd_e'({hi, lo});
  endfunction

endpackage

// File: rtl/vdsm_blank_timer.sv
module vdsm_blank_timer
  import vdsm_pkg::*;
#(
  parameter int DEAD_CYCLES = 8,
  parameter int LONG_DT     = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic gate_hi,
  input  logic gate_lo,
  output logic armed
);

  localparam int NORM_LEN  = 2 * DEAD_CYCLES;
  localparam int SHORT_LEN = DEAD_CYCLES;
  localparam int LONG_CYC  = LONG_DT * DEAD_CYCLES;
  localparam int BW        = $clog2(NORM_LEN + 1);
  localparam int IW        = $clog2(LONG_CYC + 1);

  phase_cmd_e    cmd_now;
  phase_cmd_e    cmd_q;
  logic [IW-1:0] idle_cnt;
  logic [BW-1:0] blank_cnt;
  logic          change_c;
  logic          long_idle;
  logic          turn_on;
  logic [BW-1:0] load_val;

  assign cmd_now   = decode_cmd(gate_hi, gate_lo);
  assign change_c  = (cmd_now != cmd_q);
  assign long_idle = (idle_cnt >= IW'(LONG_CYC));
  assign turn_on   = (cmd_now != PH_IDLE);
  assign load_val  = (long_idle && turn_on) ? BW'(SHORT_LEN - 1) : BW'(NORM_LEN - 1);
  assign armed     = !change_c && (blank_cnt == '0);

  // Previous command, used to detect edges
  always_ff @(posedge clk) begin
    if (rst) cmd_q <= PH_IDLE;
    else     cmd_q <= cmd_now;
  end

  // Consecutive fully-off cycles, saturating at the long threshold
  always_ff @(posedge clk) begin
    if (rst)               idle_cnt <= '0;
    else if (turn_on)      idle_cnt <= '0;
    else if (!long_idle)   idle_cnt <= idle_cnt + IW'(1);
  end

  // Blanking window: reloads on any change, counts down to zero
  always_ff @(posedge clk) begin
    if (rst)                    blank_cnt <= '0;
    else if (change_c)          blank_cnt <= load_val;
    else if (blank_cnt != '0)   blank_cnt <= blank_cnt - BW'(1);
  end

  // R5: a running window counts down by one per cycle
  a_r5_countdown: assert property (@(posedge clk) disable iff (rst)
    (!change_c && blank_cnt != '0) |=> (blank_cnt == $past(blank_cnt) - BW'(1)));

  // R6: turn-on after a long off interval gets the short window
  a_r6_short_window: assert property (@(posedge clk) disable iff (rst)
    (change_c && long_idle && turn_on) |=> (blank_cnt == BW'(SHORT_LEN - 1)));

  // R8: any other change restarts the full window
  a_r8_restart_full: assert property (@(posedge clk) disable iff (rst)
    (change_c && !(long_idle && turn_on)) |=> (blank_cnt == BW'(NORM_LEN - 1)));

  // R7: idle counter never passes the long threshold
  a_r7_idle_sat: assert property (@(posedge clk) disable iff (rst)
    idle_cnt <= IW'(LONG_CYC));

endmodule

// File: rtl/vdsm_flag_qual.sv
module vdsm_flag_qual (
  input  logic gate_hi,
  input  logic gate_lo,
  input  logic armed,
  input  logic vds_hi_over,
  input  logic vds_lo_over,
  input  logic drain_sense_fault,
  output logic hit
);

  logic hi_flag;
  logic hi_hit;
  logic lo_hit;

  // Supply-drain fault looks like a high-side short on this phase
  assign hi_flag = vds_hi_over | drain_sense_fault;
  assign hi_hit  = gate_hi & hi_flag;
  assign lo_hit  = gate_lo & vds_lo_over;
  assign hit     = armed & (hi_hit | lo_hit);

endmodule

// File: rtl/vds_fault_monitor.sv
module vds_fault_monitor #(
  parameter int NUM_PHASES  = 3,
  parameter int DEAD_CYCLES = 8,
  parameter int LONG_DT     = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_PHASES-1:0] gate_hi,
  input  logic [NUM_PHASES-1:0] gate_lo,
  input  logic [NUM_PHASES-1:0] vds_hi_over,
  input  logic [NUM_PHASES-1:0] vds_lo_over,
  input  logic                  drain_sense_fault,
  output logic [NUM_PHASES-1:0] phase_fault,
  output logic                  bridge_fault
);

  logic [NUM_PHASES-1:0] armed;
  logic [NUM_PHASES-1:0] hit;

  for (genvar p = 0; p < NUM_PHASES; p++) begin : g_phase
    vdsm_blank_timer #(
      .DEAD_CYCLES (DEAD_CYCLES),
      .LONG_DT     (LONG_DT)
    ) u_timer (
      .clk     (clk),
      .rst     (rst),
      .gate_hi (gate_hi[p]),
      .gate_lo (gate_lo[p]),
      .armed   (armed[p])
    );

    vdsm_flag_qual u_qual (
      .gate_hi           (gate_hi[p]),
      .gate_lo           (gate_lo[p]),
      .armed             (armed[p]),
      .vds_hi_over       (vds_hi_over[p]),
      .vds_lo_over       (vds_lo_over[p]),
      .drain_sense_fault (drain_sense_fault),
      .hit               (hit[p])
    );

    // R2: a fault bit only follows a cycle where some device of the phase was on
    a_r2_on_only: assert property (@(posedge clk) disable iff (rst)
      phase_fault[p] |-> $past(gate_hi[p] | gate_lo[p]));

    // R9: drain-sense fault on an armed high side faults the phase
    a_r9_drain_all: assert property (@(posedge clk) disable iff (rst)
      (drain_sense_fault && gate_hi[p] && armed[p]) |=> phase_fault[p]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_fault  <= '0;
      bridge_fault <= 1'b0;
    end else begin
      phase_fault  <= hit;
      bridge_fault <= |hit;
    end
  end

  // R10: bridge request tracks the phase vector every cycle
  a_r10_or: assert property (@(posedge clk) disable iff (rst)
    bridge_fault == (|phase_fault));

endmodule

// File: tb/vds_fault_monitor_tb.sv
`timescale 1ns/1ps
module vds_fault_monitor_tb;

  localparam int NP   = 2;
  localparam int DT   = 3;
  localparam int LDT  = 2;
  localparam int LONG = LDT * DT;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NP-1:0] gate_hi = '0;
  logic [NP-1:0] gate_lo = '0;
  logic [NP-1:0] vds_hi_over = '0;
  logic [NP-1:0] vds_lo_over = '0;
  logic          drain_sense_fault = 1'b0;
  logic [NP-1:0] phase_fault;
  logic          bridge_fault;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  vds_fault_monitor #(.NUM_PHASES(NP), .DEAD_CYCLES(DT), .LONG_DT(LDT)) u_dut (
    .clk (clk), .rst (rst),
    .gate_hi (gate_hi), .gate_lo (gate_lo),
    .vds_hi_over (vds_hi_over), .vds_lo_over (vds_lo_over),
    .drain_sense_fault (drain_sense_fault),
    .phase_fault (phase_fault), .bridge_fault (bridge_fault)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Count rising edges until phase_fault[p] reads high (R10 checked alongside)
  task automatic measure(input int p, output int edges);
    edges = 99;
    for (int i = 1; i <= 30; i++) begin
      tick();
      if (bridge_fault != (|phase_fault)) check("R10 or", bridge_fault, |phase_fault);
      if (phase_fault[p]) begin
        edges = i;
        break;
      end
    end
  endtask

  task automatic all_quiet();
    gate_hi = '0; gate_lo = '0; vds_hi_over = '0; vds_lo_over = '0;
    drain_sense_fault = 1'b0;
  endtask

  initial begin
    int e;
    all_quiet();
    repeat (3) tick();
    check("R1 reset phase", phase_fault, 0);
    check("R1 reset bridge", bridge_fault, 0);
    rst = 1'b0;
    tick();
    check("R1 after release", phase_fault, 0);

    // R2: all gates off, flags high
    vds_hi_over = '1; vds_lo_over = '1;
    repeat (12) tick();
    check("R2 off ignores flags", phase_fault, 0);
    check("R2 bridge", bridge_fault, 0);
    all_quiet(); tick();

    // R4: cross-side flags never qualify
    gate_hi[0] = 1'b1; vds_lo_over[0] = 1'b1;
    repeat (10) tick();
    check("R4 lo flag on hi cmd", phase_fault, 0);
    gate_hi[0] = 1'b0; gate_lo[0] = 1'b1; vds_lo_over[0] = 1'b0; vds_hi_over[0] = 1'b1;
    repeat (10) tick();
    check("R4 hi flag on lo cmd", phase_fault, 0);
    all_quiet(); repeat (2) tick();

    // R3/R4/R5/R6/R7/R11 sweep over phase, side and off-interval length
    for (int p = 0; p < NP; p++) begin
      for (int s = 0; s < 2; s++) begin
        for (int n = 1; n <= LONG + 2; n++) begin
          int exp_e;
          string tag;
          if (s == 0) gate_hi[p] = 1'b1; else gate_lo[p] = 1'b1;
          repeat (10) tick();
          gate_hi[p] = 1'b0; gate_lo[p] = 1'b0;
          repeat (n) tick();
          if (s == 0) begin gate_hi[p] = 1'b1; vds_hi_over[p] = 1'b1; end
          else        begin gate_lo[p] = 1'b1; vds_lo_over[p] = 1'b1; end
          exp_e = (n >= LONG) ? DT + 1 : 2 * DT + 1;
          measure(p, e);
          tag = (s == 0) ? "R3" : "R4";
          if (n >= LONG) check({tag, " R6 short window edges"}, e, exp_e);
          else           check({tag, " R5 R7 normal window edges"}, e, exp_e);
          vds_hi_over[p] = 1'b0; vds_lo_over[p] = 1'b0;
          tick();
          check("R11 not latched", phase_fault[p], 0);
          all_quiet(); tick();
        end
      end
    end

    // R8: change during a running window restarts it
    gate_lo[0] = 1'b1;
    repeat (10) tick();
    gate_lo[0] = 1'b0; gate_hi[0] = 1'b1; vds_hi_over[0] = 1'b1; vds_lo_over[0] = 1'b1;
    repeat (3) tick();
    check("R8 still blanked", phase_fault[0], 0);
    gate_hi[0] = 1'b0; gate_lo[0] = 1'b1;
    measure(0, e);
    check("R8 restart edges", e, 2 * DT + 1);
    all_quiet(); repeat (2) tick();

    // R9: drain sense fault on armed high sides
    gate_hi = '1;
    repeat (10) tick();
    check("R9 before", phase_fault, 0);
    drain_sense_fault = 1'b1;
    tick();
    check("R9 all phases", phase_fault, (1 << NP) - 1);
    check("R10 bridge", bridge_fault, 1);
    drain_sense_fault = 1'b0;
    tick();
    check("R9 release", phase_fault, 0);
    gate_hi = '0; gate_lo = '1;
    repeat (10) tick();
    drain_sense_fault = 1'b1;
    tick();
    check("R9 low side unaffected", phase_fault, 0);
    all_quiet(); repeat (2) tick();

    // R12: switching phase 0 leaves phase 1 fault intact
    gate_hi[1] = 1'b1; vds_hi_over[1] = 1'b1;
    repeat (10) tick();
    check("R12 phase1 set", phase_fault[1], 1);
    for (int k = 0; k < 8; k++) begin
      gate_hi[0] = k[0]; gate_lo[0] = ~k[0];
      tick();
      check("R12 phase1 held", phase_fault[1], 1);
      check("R10 bridge held", bridge_fault, 1);
    end
    all_quiet(); tick();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule